// File: doc/BRIEF.md
# MII Receive/Transmit Hand-over Multiplexer

This block sits between one physical MII port and two MAC implementations that can each own the port, called slot 0 and slot 1. When asked to swap, it moves the receive and transmit paths to the other slot. Each path moves on its own schedule, so that no frame is truncated and no frame is lost. The receive path is moved as soon as the line is between frames. The transmit path is moved only under three conditions: the MAC that owns it has emptied its transmit queue, the MAC is not sending, and a full minimum inter-frame gap has passed on the line.

The MAC that does not own the transmit path is held off through a per-slot hold line, so that frames it has queued cannot start early. A done flag tells the surrounding control that both paths have reached the requested slot. Moving queued frames between the two MACs is the job of other logic.

Top module: `mii_handover_mux`

## Requirements
- R1: After reset, both paths belong to slot 0, `macTxHold` is 2'b10 (only slot 1 held), and `swapDone` is low.
- R2: The receive-owning slot sees `phyRxDv`, `phyRxEr` and `phyRxD` unchanged in the same cycle. The other slot sees all three at zero.
- R3: `phyTxEn`, `phyTxEr` and `phyTxD` copy, in the same cycle, the signals of the slot that owns the transmit path.
- R4: If `swapReq` is accepted in a cycle with `phyRxDv` low, the receive path changes owner at the clock edge that ends that cycle.
- R5: A request accepted while `phyRxDv` is high is remembered. The receive path changes owner at the end of the first later cycle with `phyRxDv` low.
- R6: Once a request is accepted, the transmit path changes owner at the end of the first cycle that meets all of these: the owning slot's `macQueueEmpty` is high, `phyTxEn` is low, and `phyTxEn` was also low in the preceding IFG_CLKS (default 24) cycles.
- R7: Exactly one bit of `macTxHold` is high at all times: the bit of the slot that does not own the transmit path.
- R8: `swapDone` goes low at the edge after an accepted request. It goes high one cycle after the later of the two path changes, and stays high until the next accepted request.
- R9: A `swapReq` that arrives while either path still has a change outstanding is ignored.
- R10: Each accepted request moves both paths to the slot that does not own them at the time of the request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | MII nibble clock |
| rstN | input | 1 | Active-low synchronous reset |
| swapReq | input | 1 | Request to move both paths to the other slot |
| phyRxDv | input | 1 | Receive data valid from the PHY |
| phyRxEr | input | 1 | Receive error from the PHY |
| phyRxD | input | DATA_W | Receive nibble from the PHY |
| macRxDv | output | 2 | Per-slot receive data valid |
| macRxEr | output | 2 | Per-slot receive error |
| macRxD | output | 2 x DATA_W | Per-slot receive nibble |
| macTxEn | input | 2 | Per-slot transmit enable |
| macTxEr | input | 2 | Per-slot transmit error |
| macTxD | input | 2 x DATA_W | Per-slot transmit nibble |
| macQueueEmpty | input | 2 | Per-slot transmit queue empty |
| macTxHold | output | 2 | Per-slot hold-off: no frame may start while high |
| phyTxEn | output | 1 | Transmit enable to the PHY |
| phyTxEr | output | 1 | Transmit error to the PHY |
| phyTxD | output | DATA_W | Transmit nibble to the PHY |
| swapDone | output | 1 | Both paths are on the requested slot |

## Verification
The hardest situation to reach is a request that overlaps three things at once: an incoming frame, a transmit frame still in progress from the owning MAC, and a queue that only empties later. In that situation the two paths move many cycles apart, and a second request lands while one change is still outstanding. The stimulus randomises each of these in every round: the frame lengths, the cycle of the request, and the cycle at which the queue empties. A second request follows two cycles after the first. The non-owning MAC pulses its transmit enable, so the gap timer restarts after a change and a trailing idle stretch lets it refill. A bench model follows the requirement rules cycle by cycle and predicts owner, hold and done.

// File: rtl/mii_handover_pkg.sv
package mii_handover_pkg;

  // number of MAC slots sharing the port
  localparam int SLOT_CNT = 2;

  // per-path progress of a hand-over
  typedef enum logic {
    PATH_IDLE = 1'b0,
    PATH_WAIT = 1'b1
  } pathState_t;

  // strobes from control to datapath: move a path to the other slot
  typedef struct packed {
    logic rxFlip;
    logic txFlip;
  } swapStrobes_t;

endpackage

// File: rtl/ifg_timer.sv
module ifg_timer #(
  parameter int IFG_CLKS = 24
) (
  input  logic clk,
  input  logic rstN,
  input  logic lineBusy,
  output logic gapMet
);

  localparam int CNT_W = $clog2(IFG_CLKS + 1);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(IFG_CLKS);

  logic [CNT_W-1:0] idleCnt;

  // counts idle cycles since the line last carried a frame, saturating
  always_ff @(posedge clk) begin
    if (!rstN)               idleCnt <= CNT_MAX;
    else if (lineBusy)       idleCnt <= '0;
    else if (idleCnt != CNT_MAX) idleCnt <= idleCnt + 1'b1;
  end

  assign gapMet = (idleCnt == CNT_MAX);

endmodule

// File: rtl/handover_ctrl.sv
module handover_ctrl
  import mii_handover_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         swapReq,
  input  logic         phyRxDv,
  input  logic         phyTxEn,
  input  logic         curQueueEmpty,
  input  logic         gapMet,
  output swapStrobes_t strobes,
  output logic         swapDone
);

  pathState_t rxState, rxNext;
  pathState_t txState, txNext;
  logic accept, rxWant, txWant, armed;

  // a new hand-over is taken only when neither path has one outstanding
  assign accept = swapReq && (rxState == PATH_IDLE) && (txState == PATH_IDLE);
  assign rxWant = accept || (rxState == PATH_WAIT);
  assign txWant = accept || (txState == PATH_WAIT);

  always_comb begin
    strobes.rxFlip = rxWant && !phyRxDv;
    strobes.txFlip = txWant && curQueueEmpty && !phyTxEn && gapMet;
    rxNext = (rxWant && !strobes.rxFlip) ? PATH_WAIT : PATH_IDLE;
    txNext = (txWant && !strobes.txFlip) ? PATH_WAIT : PATH_IDLE;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rxState <= PATH_IDLE;
      txState <= PATH_IDLE;
    end else begin
      rxState <= rxNext;
      txState <= txNext;
    end
  end

  // done: cleared on acceptance, set once both paths are settled
  always_ff @(posedge clk) begin
    if (!rstN) begin
      armed    <= 1'b0;
      swapDone <= 1'b0;
    end else if (accept) begin
      armed    <= 1'b1;
      swapDone <= 1'b0;
    end else if (armed && rxState == PATH_IDLE && txState == PATH_IDLE) begin
      armed    <= 1'b0;
      swapDone <= 1'b1;
    end
  end

endmodule

// File: rtl/handover_datapath.sv
module handover_datapath
  import mii_handover_pkg::*;
#(
  parameter int DATA_W = 4
) (
  input  logic                             clk,
  input  logic                             rstN,
  input  swapStrobes_t                     strobes,
  input  logic                             phyRxDv,
  input  logic                             phyRxEr,
  input  logic [DATA_W-1:0]                phyRxD,
  output logic [SLOT_CNT-1:0]              macRxDv,
  output logic [SLOT_CNT-1:0]              macRxEr,
  output logic [SLOT_CNT-1:0][DATA_W-1:0]  macRxD,
  input  logic [SLOT_CNT-1:0]              macTxEn,
  input  logic [SLOT_CNT-1:0]              macTxEr,
  input  logic [SLOT_CNT-1:0][DATA_W-1:0]  macTxD,
  input  logic [SLOT_CNT-1:0]              macQueueEmpty,
  output logic [SLOT_CNT-1:0]              macTxHold,
  output logic                             phyTxEn,
  output logic                             phyTxEr,
  output logic [DATA_W-1:0]                phyTxD,
  output logic                             curQueueEmpty,
  output logic                             rxSel,
  output logic                             txSel
);

  // path owners; each strobe moves one path to the other slot
  always_ff @(posedge clk) begin
    if (!rstN) begin
      rxSel <= 1'b0;
      txSel <= 1'b0;
    end else begin
      if (strobes.rxFlip) rxSel <= ~rxSel;
      if (strobes.txFlip) txSel <= ~txSel;
    end
  end

  for (genvar g = 0; g < SLOT_CNT; g++) begin : g_slot
    logic ownsRx;
    assign ownsRx       = (rxSel == 1'(g));
    assign macRxDv[g]   = ownsRx && phyRxDv;
    assign macRxEr[g]   = ownsRx && phyRxEr;
    assign macRxD[g]    = ownsRx ? phyRxD : '0;
    assign macTxHold[g] = (txSel != 1'(g));
  end

  assign phyTxEn       = macTxEn[txSel];
  assign phyTxEr       = macTxEr[txSel];
  assign phyTxD        = macTxD[txSel];
  assign curQueueEmpty = macQueueEmpty[txSel];

endmodule

// File: rtl/mii_handover_mux.sv
module mii_handover_mux
  import mii_handover_pkg::*;
#(
  parameter int DATA_W   = 4,
  parameter int IFG_CLKS = 24
) (
  input  logic                             clk,
  input  logic                             rstN,
  input  logic                             swapReq,
  input  logic                             phyRxDv,
  input  logic                             phyRxEr,
  input  logic [DATA_W-1:0]                phyRxD,
  output logic [SLOT_CNT-1:0]              macRxDv,
  output logic [SLOT_CNT-1:0]              macRxEr,
  output logic [SLOT_CNT-1:0][DATA_W-1:0]  macRxD,
  input  logic [SLOT_CNT-1:0]              macTxEn,
  input  logic [SLOT_CNT-1:0]              macTxEr,
  input  logic [SLOT_CNT-1:0][DATA_W-1:0]  macTxD,
  input  logic [SLOT_CNT-1:0]              macQueueEmpty,
  output logic [SLOT_CNT-1:0]              macTxHold,
  output logic                             phyTxEn,
  output logic                             phyTxEr,
  output logic [DATA_W-1:0]                phyTxD,
  output logic                             swapDone
);

  swapStrobes_t strobes;
  logic gapMet, curQueueEmpty, rxSel, txSel;

  ifg_timer #(.IFG_CLKS(IFG_CLKS)) i_ifg_timer (
    .clk      (clk),
    .rstN     (rstN),
    .lineBusy (phyTxEn),
    .gapMet   (gapMet)
  );

  handover_ctrl i_handover_ctrl (
    .clk           (clk),
    .rstN          (rstN),
    .swapReq       (swapReq),
    .phyRxDv       (phyRxDv),
    .phyTxEn       (phyTxEn),
    .curQueueEmpty (curQueueEmpty),
    .gapMet        (gapMet),
    .strobes       (strobes),
    .swapDone      (swapDone)
  );

  handover_datapath #(.DATA_W(DATA_W)) i_handover_datapath (
    .clk           (clk),
    .rstN          (rstN),
    .strobes       (strobes),
    .phyRxDv       (phyRxDv),
    .phyRxEr       (phyRxEr),
    .phyRxD        (phyRxD),
    .macRxDv       (macRxDv),
    .macRxEr       (macRxEr),
    .macRxD        (macRxD),
    .macTxEn       (macTxEn),
    .macTxEr       (macTxEr),
    .macTxD        (macTxD),
    .macQueueEmpty (macQueueEmpty),
    .macTxHold     (macTxHold),
    .phyTxEn       (phyTxEn),
    .phyTxEr       (phyTxEr),
    .phyTxD        (phyTxD),
    .curQueueEmpty (curQueueEmpty),
    .rxSel         (rxSel),
    .txSel         (txSel)
  );

endmodule

// File: rtl/mii_handover_chk.sv
module mii_handover_chk #(
  parameter int IFG_CLKS = 24
) (
  input logic       clk,
  input logic       rstN,
  input logic       phyRxDv,
  input logic       phyTxEn,
  input logic [1:0] macRxDv,
  input logic [1:0] macQueueEmpty,
  input logic [1:0] macTxHold,
  input logic       swapDone,
  input logic       rxSel,
  input logic       txSel
);

  localparam int CNT_W = $clog2(IFG_CLKS + 1);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(IFG_CLKS);

  logic [CNT_W-1:0] idleRun;
  logic ownerEmpty;

  assign ownerEmpty = macQueueEmpty[txSel];

  always_ff @(posedge clk) begin
    if (!rstN)                   idleRun <= CNT_MAX;
    else if (phyTxEn)            idleRun <= '0;
    else if (idleRun != CNT_MAX) idleRun <= idleRun + 1'b1;
  end

  // R5
  rx_gap_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(rxSel) |-> !$past(phyRxDv));

  // R6
  tx_ifg_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(txSel) |-> ($past(idleRun) == CNT_MAX && !$past(phyTxEn)));

  // R6
  tx_drained_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(txSel) |-> $past(ownerEmpty));

  // R7
  hold_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    $countones(macTxHold) == 1 && !macTxHold[txSel]);

  // R2
  rx_exclusive_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(macRxDv));

  // R8
  done_aligned_chk: assert property (@(posedge clk) disable iff (!rstN)
    swapDone |-> (rxSel == txSel));

endmodule

bind mii_handover_mux mii_handover_chk #(.IFG_CLKS(IFG_CLKS)) i_mii_handover_chk (
  .clk           (clk),
  .rstN          (rstN),
  .phyRxDv       (phyRxDv),
  .phyTxEn       (phyTxEn),
  .macRxDv       (macRxDv),
  .macQueueEmpty (macQueueEmpty),
  .macTxHold     (macTxHold),
  .swapDone      (swapDone),
  .rxSel         (rxSel),
  .txSel         (txSel)
);

// File: tb/test_mii_handover_mux.sv
module test_mii_handover_mux;

  localparam int DW  = 4;
  localparam int IFG = 24;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic swapReq = 1'b0;
  logic phyRxDv = 1'b0, phyRxEr = 1'b0;
  logic [DW-1:0] phyRxD = '0;
  logic [1:0] macRxDv, macRxEr, macTxHold;
  logic [1:0][DW-1:0] macRxD;
  logic [1:0] macTxEn = '0, macTxEr = '0, macQueueEmpty = 2'b11;
  logic [1:0][DW-1:0] macTxD = '0;
  logic phyTxEn, phyTxEr, swapDone;
  logic [DW-1:0] phyTxD;

  int checks = 0;
  int fails  = 0;

  // bench model state, derived from the requirements
  int expRx, expTx, lowCnt;
  bit pendRx, pendTx, armed, expDone;

  always #4 clk = ~clk;

  mii_handover_mux #(.DATA_W(DW), .IFG_CLKS(IFG)) i_mii_handover_mux (
    .clk(clk), .rstN(rstN), .swapReq(swapReq),
    .phyRxDv(phyRxDv), .phyRxEr(phyRxEr), .phyRxD(phyRxD),
    .macRxDv(macRxDv), .macRxEr(macRxEr), .macRxD(macRxD),
    .macTxEn(macTxEn), .macTxEr(macTxEr), .macTxD(macTxD),
    .macQueueEmpty(macQueueEmpty), .macTxHold(macTxHold),
    .phyTxEn(phyTxEn), .phyTxEr(phyTxEr), .phyTxD(phyTxD),
    .swapDone(swapDone)
  );

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic bit gapReady(int cnt);
    return cnt >= IFG;
  endfunction

  // compare all outputs against the model for the current inputs
  task automatic checkCycle();
    int o = 1 - expRx;
    check("R2/R4/R5 owner rx dv",   macRxDv[expRx], phyRxDv);
    check("R2/R4/R5 owner rx er",   macRxEr[expRx], phyRxEr);
    check("R2/R4/R5 owner rx data", macRxD[expRx], phyRxD);
    check("R2 other rx dv",   macRxDv[o], 0);
    check("R2 other rx er",   macRxEr[o], 0);
    check("R2 other rx data", macRxD[o], 0);
    check("R3/R6/R10 tx en",   phyTxEn, macTxEn[expTx]);
    check("R3/R6/R10 tx er",   phyTxEr, macTxEr[expTx]);
    check("R3/R6/R10 tx data", phyTxD, macTxD[expTx]);
    check("R7 hold", macTxHold, (expTx == 0) ? 2 : 1);
    check("R8/R9 done", swapDone, expDone);
  endtask

  // advance the model across the coming clock edge
  task automatic modelStep();
    bit accept, rxGo, txGo, selEn;
    selEn  = macTxEn[expTx];
    accept = swapReq && !pendRx && !pendTx;
    rxGo   = (accept || pendRx) && !phyRxDv;
    txGo   = (accept || pendTx) && macQueueEmpty[expTx] && !selEn && gapReady(lowCnt);
    if (accept) begin
      expDone = 0; armed = 1;
    end else if (armed && !pendRx && !pendTx) begin
      expDone = 1; armed = 0;
    end
    pendRx = (accept || pendRx) && !rxGo;
    pendTx = (accept || pendTx) && !txGo;
    lowCnt = selEn ? 0 : ((lowCnt < IFG) ? lowCnt + 1 : IFG);
    if (rxGo) expRx = 1 - expRx;
    if (txGo) expTx = 1 - expTx;
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  initial begin
    #(8 * 200000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    int seedDummy;
    seedDummy = $urandom(32'd1357);
    expRx = 0; expTx = 0; lowCnt = IFG;
    pendRx = 0; pendTx = 0; armed = 0; expDone = 0;
    repeat (3) tick();
    rstN = 1'b1;
    tick();
    // R1: reset state
    check("R1 hold after reset", macTxHold, 2);
    check("R1 done after reset", swapDone, 0);
    phyRxDv = 1'b1;
    #1;
    check("R1 rx on slot 0", macRxDv, 1);
    phyRxDv = 1'b0;

    // R4: directed immediate receive switch on an idle line
    swapReq = 1'b1;
    #1;
    checkCycle();
    modelStep();
    tick();
    swapReq = 1'b0;
    phyRxDv = 1'b1;
    #1;
    check("R4 rx moved at once", macRxDv, 2);
    check("R10 tx moved to slot 1", macTxHold, 1);
    phyRxDv = 1'b0;
    #1;
    checkCycle();
    modelStep();
    tick();
    check("R8 done one cycle later", swapDone, 1);

    for (int it = 0; it < 40; it++) begin
      int rxLen, txLen, qAt, reqAt, owner;
      rxLen = $urandom_range(40, 0);
      txLen = $urandom_range(30, 0);
      qAt   = $urandom_range(60, 0);
      reqAt = $urandom_range(50, 0);
      owner = expTx;
      for (int t = 0; t < 170; t++) begin
        swapReq  = (t == reqAt) || (t == reqAt + 2);
        phyRxDv  = (t < rxLen);
        phyRxEr  = (t < rxLen) && (t % 9 == 5);
        phyRxD   = DW'(t);
        macTxEn[owner]       = (t < txLen);
        macTxEr[owner]       = (t < txLen) && (t % 11 == 3);
        macTxD[owner]        = DW'(t + 3);
        macQueueEmpty[owner] = (t >= qAt);
        macTxEn[1 - owner]   = (t < 120) && (t % 7 == 0);
        macTxEr[1 - owner]   = 1'b0;
        macTxD[1 - owner]    = DW'($urandom_range(15, 0));
        macQueueEmpty[1 - owner] = 1'b1;
        #1;
        checkCycle();
        modelStep();
        tick();
      end
    end

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

endmodule